// File: doc/BRIEF.md
# Multitask Microcode Task Scheduler

This block lets sixteen hardware tasks share one microcoded engine. Each task has a fixed priority. Every cycle, the block takes a vector of wakeup requests. At each microinstruction boundary it picks the highest-numbered requesting task. Task 0 interprets the instruction stream and always requests, so it runs whenever nothing else does. Task 0 has the lowest priority and task 15 the highest.

The block holds one saved microaddress per task in a small register file. The address presented to the control store is always the saved address of the running task. At a boundary, the sequencer's next address is written into the outgoing task's entry. On that same edge the incoming task's saved address becomes the output, so a switch costs no extra cycles.

Two wakeups come from inside the block:
- A free-running timer sets a pending wakeup for a housekeeping task once per period. The period is a parameter in cycles: 224 cycles of 170 ns is about 38 µs.
- A memory-fault input sets a pending wakeup for a fault task.

Both pending flags hold until the task they belong to acknowledges while it is running.

Top module: `task_sched`

## Requirements
- R1: While reset is held and just after it, the running task is 0, the switch pulse is low, and every task's saved address equals START_BASE plus its task number.
- R2: On a clock edge with cycle_done high, the running task becomes the highest-numbered bit set in the combined request vector. That vector is wake_req OR the two internal pending wakeups OR bit 0.
- R3: The running task does not change on any edge where cycle_done is low, whatever the requests are.
- R4: When no task above 0 requests at a boundary, task 0 is selected, even if wake_req bit 0 is low.
- R5: On a cycle_done edge, next_addr is stored for the task that was running. The cycle after the edge, cur_addr shows the saved address of the task now running. If the task did not change, that is the value just stored.
- R6: task_switch is high for exactly the one cycle after an edge on which the running task changed, and low otherwise.
- R7: The timer wakeup for task TIMER_TASK (default 14) is set on the TIMER_CYCLES-th edge after reset and on every TIMER_CYCLES-th edge after that.
- R8: A pulse on fault_in sets a pending wakeup for task FAULT_TASK (default 15). The wakeup stays pending until ack is high while that task is running.
- R9: An ack given while a task other than the owner of a pending wakeup is running leaves that wakeup pending.
- R10: If a set and a clear of the same pending wakeup happen on one edge, the set wins and the wakeup stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_req | input | 16 | Wakeup requests from device controllers, one bit per task |
| cycle_done | input | 1 | Marks the last cycle of the current microinstruction |
| next_addr | input | 12 | Next microaddress of the running task, from the sequencer |
| fault_in | input | 1 | Memory error report |
| ack | input | 1 | Running task releases its internal wakeup |
| cur_task | output | 4 | Number of the running task |
| cur_addr | output | 12 | Microaddress to fetch for the running task |
| task_switch | output | 1 | One-cycle pulse after the running task changes |

## Verification
The assertions check these properties on every cycle:
- The running task holds between boundaries.
- A request from task 15 wins at a boundary.
- Task 0 is chosen when nothing above it requests.
- The switch pulse appears only after a real change.
- Pending wakeups are set on a timer tick and hold until their own acknowledge.

Only the bench scenarios can show the following:
- Saved addresses survive when control leaves a task and returns to it.
- The timer fires on the exact edge counted from reset and repeats at its period.
- An acknowledge from the wrong task is ignored.
- A set wins over a clear on the same edge.

// File: rtl/task_sched.sv
module task_sched #(
  parameter int NTASK        = 16,
  parameter int AW           = 12,
  parameter int START_BASE   = 0,
  parameter int TIMER_CYCLES = 224,
  parameter int TIMER_TASK   = 14,
  parameter int FAULT_TASK   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTASK-1:0] wake_req,
  input  logic             cycle_done,
  input  logic [AW-1:0]    next_addr,
  input  logic             fault_in,
  input  logic             ack,
  output logic [$clog2(NTASK)-1:0] cur_task,
  output logic [AW-1:0]    cur_addr,
  output logic             task_switch
);
  localparam int TW = $clog2(NTASK);
  localparam int CW = $clog2(TIMER_CYCLES);

  logic [AW-1:0]    mpc [NTASK];
  logic [CW-1:0]    tcnt;
  logic             timer_pend, fault_pend;
  logic             tick, timer_clr, fault_clr, timer_nxt, fault_nxt;
  logic [NTASK-1:0] req;
  logic [TW-1:0]    sel;

  assign tick      = (tcnt == CW'(TIMER_CYCLES - 1));
  assign timer_clr = ack && (cur_task == TW'(TIMER_TASK));
  assign fault_clr = ack && (cur_task == TW'(FAULT_TASK));
  assign timer_nxt = tick     | (timer_pend & ~timer_clr);
  assign fault_nxt = fault_in | (fault_pend & ~fault_clr);
  assign cur_addr  = mpc[cur_task];

  always_comb begin
    req             = wake_req;
    req[TIMER_TASK] = wake_req[TIMER_TASK] | timer_nxt;
    req[FAULT_TASK] = wake_req[FAULT_TASK] | fault_nxt;
    req[0]          = 1'b1;
    sel = '0;
    for (int i = 0; i < NTASK; i++)
      if (req[i]) sel = TW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt       <= '0;
      timer_pend <= 1'b0;
      fault_pend <= 1'b0;
    end else begin
      tcnt       <= tick ? '0 : tcnt + 1'b1;
      timer_pend <= timer_nxt;
      fault_pend <= fault_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_task    <= '0;
      task_switch <= 1'b0;
    end else begin
      task_switch <= cycle_done && (sel != cur_task);
      if (cycle_done) cur_task <= sel;
    end
  end

  generate
    for (genvar g = 0; g < NTASK; g++) begin : g_mpc
      always_ff @(posedge clk) begin
        if (!rst_n)
          mpc[g] <= AW'(START_BASE + g);
        else if (cycle_done && cur_task == TW'(g))
          mpc[g] <= next_addr;
      end
    end
  endgenerate

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_done |=> $stable(cur_task));
  // R2
  top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && wake_req[NTASK-1] |=> cur_task == TW'(NTASK - 1));
  // R4
  idle_task0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && req[NTASK-1:1] == '0 |=> cur_task == '0);
  // R6
  switch_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |-> cur_task != $past(cur_task));
  // R7
  timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer_pend);
  // R8
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pend && !(ack && cur_task == TW'(FAULT_TASK)) |=> fault_pend);
endmodule

// File: tb/test_task_sched.sv
module test_task_sched;
  localparam int P = 300;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] wake_req = '0;
  logic        cycle_done = 0;
  logic [11:0] next_addr = '0;
  logic        fault_in = 0;
  logic        ack = 0;
  logic [3:0]  cur_task;
  logic [11:0] cur_addr;
  logic        task_switch;
  int errors = 0, checks = 0, ncyc = 0;

  task_sched #(.TIMER_CYCLES(P)) i_task_sched (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .cycle_done(cycle_done),
    .next_addr(next_addr), .fault_in(fault_in), .ack(ack),
    .cur_task(cur_task), .cur_addr(cur_addr), .task_switch(task_switch));

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) step();
    chk("R1 task", cur_task, 0);
    chk("R1 addr", cur_addr, 0);
    chk("R1 switch", task_switch, 0);
    rst_n = 1;
    step();
    chk("R1 task after", cur_task, 0);
  endtask

  task automatic t_prio();
    wake_req = 16'h0288; cycle_done = 1; next_addr = 12'h100;
    step();
    chk("R2 pick 9", cur_task, 9);
    chk("R6 pulse", task_switch, 1);
    chk("R5 start addr", cur_addr, 9);
    chk("R1 start of 9", cur_addr, 9);
  endtask

  task automatic t_hold();
    cycle_done = 0; wake_req = 16'h1000;
    repeat (3) step();
    chk("R3 hold", cur_task, 9);
    chk("R6 no pulse", task_switch, 0);
  endtask

  task automatic t_return();
    wake_req = '0; cycle_done = 1; next_addr = 12'h02A;
    step();
    chk("R5 back to 0", cur_task, 0);
    chk("R5 saved 0", cur_addr, 12'h100);
    wake_req = 16'h0200; next_addr = 12'h101;
    step();
    chk("R5 saved 9", cur_addr, 12'h02A);
    next_addr = 12'h02B;
    step();
    chk("R6 same task", task_switch, 0);
    chk("R5 same task wb", cur_addr, 12'h02B);
  endtask

  task automatic t_idle();
    wake_req = '0; next_addr = 12'h055;
    step();
    chk("R4 idle", cur_task, 0);
    chk("R6 pulse back", task_switch, 1);
    cycle_done = 0;
  endtask

  task automatic t_fault();
    fault_in = 1; step(); fault_in = 0;
    ack = 1; step(); ack = 0;
    chk("R3 no boundary", cur_task, 0);
    cycle_done = 1; next_addr = 12'h056;
    step();
    chk("R9 fault kept", cur_task, 15);
    fault_in = 1; ack = 1; next_addr = 12'h300;
    step();
    fault_in = 0; ack = 0;
    chk("R10 set wins", cur_task, 15);
    ack = 1; next_addr = 12'h301;
    step();
    ack = 0;
    chk("R8 released", cur_task, 0);
    chk("R5 saved 0 again", cur_addr, 12'h056);
    step();
    chk("R8 stays clear", cur_task, 0);
  endtask

  task automatic t_timer();
    cycle_done = 1; wake_req = '0;
    while (ncyc < P - 1) step();
    chk("R7 before tick", cur_task, 0);
    step();
    chk("R7 tick edge", ncyc, P);
    chk("R7 timer runs", cur_task, 14);
    ack = 1; step(); ack = 0;
    chk("R7 ack clears", cur_task, 0);
    while (ncyc < 2 * P - 1) step();
    chk("R7 before 2nd", cur_task, 0);
    step();
    chk("R7 second tick", cur_task, 14);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_prio(); t_hold(); t_return(); t_idle(); t_fault(); t_timer();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule